// File: doc/BRIEF.md
# Halved-Table Distributed-Arithmetic Partial-Sum Unit

This unit serves a bit-serial distributed-arithmetic FIR datapath. Every bit-clock the filter presents one bit from each tap's sample as a K-bit slice address. The unit returns the signed sum of the coefficients whose address bit is set. The filter's shift-and-accumulate logic consumes that sum, and that logic is not part of this block.

A direct implementation would store all 2^K possible sums. This unit never holds that full table. A word whose top address bit is one equals the word with that bit cleared plus the coefficient of that tap. So each top bit can be removed from storage and handled by a 2:1 multiplexer (the coefficient or zero) followed by an adder. The parameter `TABLE_BITS` sets how many low address bits stay in a small stored table of 2^TABLE_BITS words. That table is computed at elaboration from the coefficient parameter. The remaining address bits each get one fold stage. At `TABLE_BITS = 0` no table is left, and the unit is built only from multiplexers and adders.

The result is either combinational or registered once, selected by `OUT_MODE`.

Top module: `da_halved_sum`

## Requirements
- R1: For every slice address, `sum_o` read as a two's-complement number equals the sum of the coefficients c[k] for each k where `addr_i[k]` is 1. Coefficient c[k] is the signed field `COEFS[k*COEF_W +: COEF_W]`.
- R2: For the same coefficients and address, the result is identical for every `TABLE_BITS` from 0 to `NUM_TAPS`.
- R3: `sum_o` is `COEF_W + $clog2(NUM_TAPS)` bits wide. No sum overflows, including the case where every tap is selected and every coefficient is the most negative value -2^(COEF_W-1).
- R4: Address 0 gives `sum_o` = 0.
- R5: An address with only bit k set gives exactly c[k], sign-extended.
- R6: With `OUT_MODE` = OUT_FLOP, `sum_o` shows the result for the `addr_i` sampled at the previous rising edge of `clk_i`. With OUT_COMB, `sum_o` follows `addr_i` with no clock edge.
- R7: In OUT_FLOP mode, driving `rst_ni` low forces `sum_o` to 0 at once, without waiting for a clock edge.
- R8: For every address bit m and every address a with bit m set, result(a) - result(a with bit m cleared) = c[m]. This is the identity that allows bit m to be folded out of storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | NUM_TAPS | Slice address. Bit k selects tap k |
| sum_o | output | COEF_W+$clog2(NUM_TAPS) | Signed sum of the selected coefficients |

## Verification
The clocked properties assume that `addr_i` is settled at each rising edge and that `rst_ni` starts low at time zero. The bench therefore changes the address only on falling edges and holds reset from the first instant. The overflow bound assumes that every coefficient fits in `COEF_W` signed bits. The bench includes an instance whose coefficients are all at the negative limit, so the widest sum is actually produced. All 2^K addresses are swept through instances with different table sizes. The differences between the observed outputs are then compared with each coefficient, which tests the fold identity at the ports.

// File: rtl/da_half_pkg.sv
package da_half_pkg;

  typedef enum bit {
    OUT_COMB = 1'b0,
    OUT_FLOP = 1'b1
  } out_mode_e;

  // growth bits needed so that a sum of taps signed words cannot wrap
  function automatic int unsigned sum_width(int unsigned coef_w, int unsigned taps);
    return coef_w + $clog2(taps);
  endfunction

endpackage

// File: rtl/da_part_table.sv
module da_part_table #(
  parameter int unsigned TAPS_IN = 4,
  parameter int unsigned COEF_W  = 12,
  parameter int unsigned SUM_W   = 15,
  parameter logic [TAPS_IN*COEF_W-1:0] COEFS = '0,
  localparam int unsigned DEPTH = 1 << TAPS_IN
) (
  input  logic [TAPS_IN-1:0] addr_i,
  output logic [SUM_W-1:0]   word_o
);

  function automatic logic [SUM_W-1:0] entry(int unsigned idx);
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int unsigned k = 0; k < TAPS_IN; k++) begin
      if (((idx >> k) & 1) != 0)
        acc = acc + SUM_W'(signed'(COEFS[k*COEF_W +: COEF_W]));
    end
    return acc;
  endfunction

  logic [SUM_W-1:0] words [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign words[i] = entry(i);
  end

  assign word_o = words[addr_i];

endmodule

// File: rtl/da_fold_stage.sv
module da_fold_stage #(
  parameter int unsigned COEF_W = 12,
  parameter int unsigned SUM_W  = 15,
  parameter logic [COEF_W-1:0] COEF = '0
) (
  input  logic             sel_i,
  input  logic [SUM_W-1:0] sum_i,
  output logic [SUM_W-1:0] sum_o
);

  localparam logic signed [COEF_W-1:0] COEF_S = COEF;
  localparam logic [SUM_W-1:0] COEF_EXT = SUM_W'(COEF_S);

  logic [SUM_W-1:0] addend;

  always_comb begin
    addend = sel_i ? COEF_EXT : '0;
    sum_o  = sum_i + addend;
  end

endmodule

// File: rtl/da_halved_sum.sv
module da_halved_sum
  import da_half_pkg::*;
#(
  parameter int unsigned NUM_TAPS   = 5,
  parameter int unsigned COEF_W     = 12,
  parameter int unsigned TABLE_BITS = 4,
  parameter out_mode_e   OUT_MODE   = OUT_FLOP,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS =
    {12'h001, 12'hF00, 12'h123, 12'h800, 12'h7FF},
  localparam int unsigned SUM_W = sum_width(COEF_W, NUM_TAPS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TAPS-1:0] addr_i,
  output logic [SUM_W-1:0]    sum_o
);

  localparam int unsigned NUM_FOLD = NUM_TAPS - TABLE_BITS;

  logic [SUM_W-1:0] chain [NUM_FOLD+1];
  logic [SUM_W-1:0] result;

  // stored part: low TABLE_BITS address bits
  if (TABLE_BITS == 0) begin : g_no_table
    assign chain[0] = '0;
  end else begin : g_table
    da_part_table #(
      .TAPS_IN(TABLE_BITS),
      .COEF_W (COEF_W),
      .SUM_W  (SUM_W),
      .COEFS  (COEFS[TABLE_BITS*COEF_W-1:0])
    ) u_table (
      .addr_i(addr_i[TABLE_BITS-1:0]),
      .word_o(chain[0])
    );
  end

  // folded part: one mux/adder per remaining address bit
  for (genvar j = 0; j < NUM_FOLD; j++) begin : g_fold
    da_fold_stage #(
      .COEF_W(COEF_W),
      .SUM_W (SUM_W),
      .COEF  (COEFS[(TABLE_BITS+j)*COEF_W +: COEF_W])
    ) u_stage (
      .sel_i(addr_i[TABLE_BITS+j]),
      .sum_i(chain[j]),
      .sum_o(chain[j+1])
    );
  end

  assign result = chain[NUM_FOLD];

  localparam int signed LIM_NEG = -(int'(NUM_TAPS) * (1 <<< (COEF_W-1)));
  localparam int signed LIM_POS = int'(NUM_TAPS) * ((1 <<< (COEF_W-1)) - 1);

  if (OUT_MODE == OUT_FLOP) begin : g_flop
    logic [SUM_W-1:0] sum_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sum_q <= '0;
      else         sum_q <= result;
    end

    assign sum_o = sum_q;

    assert_reset_clear_R7: assert property (@(posedge clk_i)
      !rst_ni |-> sum_o == '0);

    assert_zero_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      addr_i == '0 |=> sum_o == '0);

    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_onehot_chk
      assert_single_tap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        addr_i == NUM_TAPS'(1 << k) |=>
          sum_o == SUM_W'(signed'(COEFS[k*COEF_W +: COEF_W])));
    end
  end else begin : g_comb
    assign sum_o = result;

    assert_zero_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      addr_i == '0 |-> sum_o == '0);

    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_onehot_chk
      assert_single_tap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        addr_i == NUM_TAPS'(1 << k) |->
          sum_o == SUM_W'(signed'(COEFS[k*COEF_W +: COEF_W])));
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(signed'(sum_o)) >= LIM_NEG) && (int'(signed'(sum_o)) <= LIM_POS));

endmodule

// File: tb/da_halved_sum_test.sv
module da_halved_sum_test;
  import da_half_pkg::*;

  localparam int K  = 5;
  localparam int W  = 12;
  localparam int OW = 15;
  localparam int N  = 1 << K;
  localparam logic [K*W-1:0] CF_MAIN = {12'h001, 12'hF00, 12'h123, 12'h800, 12'h7FF};
  localparam logic [K*W-1:0] CF_NEG  = {K{12'h800}};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [K-1:0] addr = '0;
  logic [OW-1:0] s_r4, s_r0, s_r2, s_r5, s_cmb, s_neg;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int obs [N];

  always #5 clk = ~clk;

  da_halved_sum #(.TABLE_BITS(4), .OUT_MODE(OUT_FLOP), .COEFS(CF_MAIN)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .sum_o(s_r4));
  da_halved_sum #(.TABLE_BITS(0), .OUT_MODE(OUT_FLOP), .COEFS(CF_MAIN)) u_r0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .sum_o(s_r0));
  da_halved_sum #(.TABLE_BITS(2), .OUT_MODE(OUT_FLOP), .COEFS(CF_MAIN)) u_r2 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .sum_o(s_r2));
  da_halved_sum #(.TABLE_BITS(5), .OUT_MODE(OUT_FLOP), .COEFS(CF_MAIN)) u_r5 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .sum_o(s_r5));
  da_halved_sum #(.TABLE_BITS(3), .OUT_MODE(OUT_COMB), .COEFS(CF_MAIN)) u_cmb (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .sum_o(s_cmb));
  da_halved_sum #(.TABLE_BITS(1), .OUT_MODE(OUT_FLOP), .COEFS(CF_NEG)) u_neg (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .sum_o(s_neg));

  function automatic int coef(logic [K*W-1:0] cf, int k);
    return int'($signed(cf[k*W +: W]));
  endfunction

  function automatic int ref_sum(logic [K*W-1:0] cf, int a);
    int s = 0;
    for (int k = 0; k < K; k++) if (a[k]) s += coef(cf, k);
    return s;
  endfunction

  function automatic int as_int(logic [OW-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive on falling edge, let one rising edge pass, sample 2 ns later
  task automatic apply(int a);
    @(negedge clk);
    addr = K'(a);
    @(posedge clk);
    #2;
  endtask

  task automatic test_reset;
    #3;
    chk("R7 reset r4", as_int(s_r4), 0);
    chk("R7 reset r0", as_int(s_r0), 0);
    chk("R7 reset neg", as_int(s_neg), 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic test_sweep;
    for (int a = 0; a < N; a++) begin
      apply(a);
      chk("R1 table4", as_int(s_r4), ref_sum(CF_MAIN, a));
      chk("R2 table0", as_int(s_r0), ref_sum(CF_MAIN, a));
      chk("R2 table2", as_int(s_r2), ref_sum(CF_MAIN, a));
      chk("R2 table5", as_int(s_r5), ref_sum(CF_MAIN, a));
      chk("R6 comb3", as_int(s_cmb), ref_sum(CF_MAIN, a));
      obs[a] = as_int(s_r0);
    end
  endtask

  task automatic test_zero;
    apply(0);
    chk("R4 zero flop", as_int(s_r4), 0);
    chk("R4 zero comb", as_int(s_cmb), 0);
  endtask

  task automatic test_onehot;
    for (int k = 0; k < K; k++) begin
      apply(1 << k);
      chk("R5 single tap r0", as_int(s_r0), coef(CF_MAIN, k));
      chk("R5 single tap r5", as_int(s_r5), coef(CF_MAIN, k));
    end
  endtask

  task automatic test_fold;
    for (int m = 0; m < K; m++)
      for (int a = 0; a < N; a++)
        if (a[m]) chk("R8 fold identity", obs[a] - obs[a & ~(1 << m)], coef(CF_MAIN, m));
  endtask

  task automatic test_extreme;
    apply(N - 1);
    chk("R3 all negative", as_int(s_neg), -K * (1 << (W-1)));
    chk("R3 max positive sel", as_int(s_r4), ref_sum(CF_MAIN, N - 1));
    apply(5'b00011);
    chk("R3 two negative", as_int(s_neg), -2 * (1 << (W-1)));
  endtask

  task automatic test_latency;
    apply(5'b00101);
    @(negedge clk);
    addr = 5'b11010;
    #1;
    chk("R6 flop holds", as_int(s_r4), ref_sum(CF_MAIN, 5'b00101));
    chk("R6 comb follows", as_int(s_cmb), ref_sum(CF_MAIN, 5'b11010));
    @(posedge clk);
    #2;
    chk("R6 flop updates", as_int(s_r4), ref_sum(CF_MAIN, 5'b11010));
  endtask

  task automatic test_async_reset;
    apply(5'b10110);
    chk("R7 pre reset", as_int(s_r2), ref_sum(CF_MAIN, 5'b10110));
    #1;
    rst_ni = 1'b0;
    #1;
    chk("R7 async clear r2", as_int(s_r2), 0);
    chk("R7 async clear neg", as_int(s_neg), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    #2;
    chk("R7 recover", as_int(s_r2), ref_sum(CF_MAIN, 5'b10110));
  endtask

  initial begin
    test_reset();
    test_sweep();
    test_zero();
    test_onehot();
    test_fold();
    test_extreme();
    test_latency();
    test_async_reset();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule